// File: doc/BRIEF.md
# Two-bit burst address generator

This block produces the word address for a four-beat burst on a synchronous memory. When a burst begins it captures an external address. After that it steps the two lowest address bits through four beats while the upper bits stay exactly as they were captured. A burst can be opened by either of two active-low load strobes, and both have the same effect.

The beats follow one of two orders, and the order is chosen when the burst is loaded. In linear order the low bits count up modulo 4 from the start value. In interleaved order the low bits are the start value XOR the beat number. An active-low advance input steps the burst by one beat. While advance is inactive and no strobe is active, the address holds (burst suspend). After the fourth beat the sequence wraps back to the start. The block ignores data direction and output enable, so a read whose drivers are off still steps the address like any other read.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the address register clears, so `addr_out` reads all zeros after that edge.
- R2: A low `ld_cpu_n` at a rising edge loads `ext_addr`. From the next cycle `addr_out` equals the loaded value.
- R3: A low `ld_ctl_n` at a rising edge loads `ext_addr` in the same way as R2.
- R4: With `order_il` low at load time, each advance adds one, modulo 4, to `addr_out[1:0]`. A start of 01 gives 01, 10, 11, 00.
- R5: With `order_il` high at load time, the low bits on beat k (k = 0..3) equal the start value XOR k. A start of 01 gives 01, 00, 11, 10.
- R6: The fourth advance after a load returns `addr_out` to the loaded value, in both orders.
- R7: When both strobes are high and `adv_n` is high at a rising edge, `addr_out` is unchanged after that edge.
- R8: An advance never changes `addr_out[ADDR_W-1:2]`. Only a load writes those bits.
- R9: A load takes priority over an advance in the same cycle. The result equals `ext_addr`, with no beat added.
- R10: Changing `order_il` between loads has no effect on the order of the burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | Address captured when a burst is loaded |
| ld_cpu_n | input | 1 | First load strobe, active low |
| ld_ctl_n | input | 1 | Second load strobe, active low |
| adv_n | input | 1 | Step to the next beat, active low |
| order_il | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current word address |

## Verification
The assertions assume that the strobes, `adv_n` and `order_il` always carry a known 0 or 1. An undriven order select is treated as high only by the board-level convention, not by this logic. The assertions also assume that reset is applied before the first burst. The bench drives only known values, changes inputs away from the rising edge, and holds reset for several cycles at the start. The consecutive-beat properties therefore always compare two well-defined addresses.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ld_cpu_n,
  input  logic              ld_ctl_n,
  input  logic              adv_n,
  input  logic              order_il,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UP_W = ADDR_W - 2;

  logic [UP_W-1:0] upper_q;
  logic [1:0]      start_q;
  logic [1:0]      beat_q;
  logic            il_q;
  logic            load;
  logic [1:0]      low;

  assign load = ~ld_cpu_n | ~ld_ctl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      il_q    <= 1'b0;
    end else if (load) begin
      upper_q <= ext_addr[ADDR_W-1:2];
      start_q <= ext_addr[1:0];
      beat_q  <= '0;
      il_q    <= order_il;
    end else if (!adv_n) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign low      = il_q ? (start_q ^ beat_q) : (start_q + beat_q);
  assign addr_out = {upper_q, low};

  // R2 R3 R9: any strobe loads the external address exactly
  assert_load_exact_R2: assert property (@(posedge clk) disable iff (rst)
    (!ld_cpu_n || !ld_ctl_n) |=> addr_out == $past(ext_addr));

  // R7: suspend holds the address
  assert_suspend_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ld_cpu_n && ld_ctl_n && adv_n) |=> $stable(addr_out));

  // R8: upper bits untouched without a load
  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_cpu_n && ld_ctl_n) |=> $stable(addr_out[ADDR_W-1:2]));

  // R4: linear step adds one modulo 4
  assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ld_cpu_n && ld_ctl_n && !adv_n && !il_q) |=>
      addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

  // R5: interleaved step always toggles bit 0
  assert_il_step_R5: assert property (@(posedge clk) disable iff (rst)
    (ld_cpu_n && ld_ctl_n && !adv_n && il_q) |=>
      addr_out[0] != $past(addr_out[0]));
endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
  localparam int W = 18;
  logic clk = 1'b0;
  logic rst, ld_cpu_n, ld_ctl_n, adv_n, order_il;
  logic [W-1:0] ext_addr, addr_out;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) u_dut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .ld_cpu_n(ld_cpu_n),
    .ld_ctl_n(ld_ctl_n), .adv_n(adv_n), .order_il(order_il), .addr_out(addr_out)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    total++;
    if (addr_out !== exp) begin
      bad++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic idle();
    ld_cpu_n = 1; ld_ctl_n = 1; adv_n = 1;
  endtask

  task automatic load(input logic [W-1:0] a, input logic use_ctl, input logic il);
    ext_addr = a; order_il = il; adv_n = 1;
    ld_cpu_n = use_ctl; ld_ctl_n = !use_ctl;
    cyc();
    idle();
  endtask

  task automatic advance();
    adv_n = 0; cyc(); adv_n = 1;
  endtask

  function automatic logic [W-1:0] beat(input logic [W-1:0] s, input logic il, input int k);
    logic [1:0] kk = 2'(k);
    return {s[W-1:2], il ? (s[1:0] ^ kk) : (s[1:0] + kk)};
  endfunction

  task automatic t_reset();
    rst = 1; idle(); ext_addr = '1; order_il = 0;
    repeat (3) cyc();
    check("R1", '0);
    rst = 0;
  endtask

  task automatic t_linear();
    logic [W-1:0] s = 18'h15555;
    load(s, 0, 0);
    check("R2", s);
    for (int k = 1; k < 4; k++) begin
      advance(); check("R4/R8", beat(s, 0, k));
    end
    advance(); check("R6 linear wrap", s);
  endtask

  task automatic t_interleave();
    logic [W-1:0] s = 18'h3FF01;
    load(s, 1, 1);
    check("R3", s);
    for (int k = 1; k < 4; k++) begin
      advance(); check("R5/R8", beat(s, 1, k));
    end
    advance(); check("R6 interleaved wrap", s);
    s = 18'h0A5A6;
    load(s, 0, 1);
    for (int k = 1; k < 4; k++) begin
      advance(); check("R5 start 10", beat(s, 1, k));
    end
  endtask

  task automatic t_suspend();
    logic [W-1:0] s = 18'h22220;
    load(s, 0, 0);
    advance(); check("R4", beat(s, 0, 1));
    cyc(); check("R7 hold", beat(s, 0, 1));
    cyc(); check("R7 hold", beat(s, 0, 1));
    advance(); check("R7 resume", beat(s, 0, 2));
  endtask

  task automatic t_priority();
    logic [W-1:0] s = 18'h01233;
    load(18'h00000, 0, 0);
    advance();
    ext_addr = s; order_il = 1; ld_cpu_n = 0; ld_ctl_n = 0; adv_n = 0;
    cyc(); idle();
    check("R9 load over advance", s);
    advance(); check("R9 then step", beat(s, 1, 1));
  endtask

  task automatic t_mode_hold();
    logic [W-1:0] s = 18'h10003;
    load(s, 1, 0);
    order_il = 1;
    advance(); check("R10", beat(s, 0, 1));
    advance(); check("R10", beat(s, 0, 2));
    advance(); check("R10", beat(s, 0, 3));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_linear();
    t_interleave();
    t_suspend();
    t_priority();
    t_mode_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule